// File: doc/BRIEF.md
# PS/2 Mouse Packet Host

This block is the host side of a two-wire PS/2 link to a mouse. After reset it takes the bus and sends the command that starts the mouse streaming. It then throws away whatever the mouse sends until the acknowledge byte arrives. From that point it assembles movement packets. Each finished packet is reported on a one-cycle valid strobe. The strobe carries 9-bit two's complement X and Y deltas, three button states, two overflow flags and, when the wheel extension is enabled, a signed wheel delta.

Both bus lines are open-collector. The block never drives a line high. It only asserts a pull-low request for the clock line and for the data line, and it reads both lines back through a two-stage synchronizer. When a received frame is corrupt during streaming, the block pulses an error flag and drops the partial packet. It then asks the mouse to repeat its last packet and waits for the acknowledge before it assembles again. Tracking the cursor position is left to the logic downstream.

Top module: `mouse_pkt_host`

## Requirements
- R1: After reset the host asserts `ps2ClkLow` for at least `INHIBIT_CYC` cycles. It asserts `ps2DataLow` before it releases the clock (request to send). While in reset both pull-low outputs, `pktValid` and `errFlag` are 0.
- R2: The first command byte is 0xF4. It goes out least significant bit first, followed by an odd parity bit and a released (1) stop bit. The host presents a new bit after each falling edge of the device clock, and the device acknowledges on the 11th edge.
- R3: Until a good 0xFA byte has been received after a command, every received byte is ignored. No `pktValid` and no `errFlag` are produced, even for frames with bad parity.
- R4: A received frame is 11 bits sampled on falling clock edges: start 0, eight data bits least significant first, odd parity, stop 1. During streaming, a frame that breaks any of these rules gives exactly one `errFlag` pulse and never coincides with `pktValid`.
- R5: Packet bytes arrive in the order status, X, Y, then wheel when `WHEEL_EN` is 1. `pktValid` is a single-cycle pulse after the last byte.
- R6: `deltaX` = {status bit 4, X byte} and `deltaY` = {status bit 5, Y byte}, each read as 9-bit two's complement.
- R7: `buttons[0]`, `buttons[1]` and `buttons[2]` are status bits 0 (left), 1 (right) and 2 (middle). `ovfX` is status bit 6 and `ovfY` is status bit 7.
- R8: With `WHEEL_EN` = 1, `wheel` is the fourth byte, read as 8-bit two's complement.
- R9: A byte in the status position whose bit 3 is 0 is dropped. The next byte is then tried as a status byte.
- R10: A corrupt frame during streaming discards the partial packet. The host then sends 0xFE with the R1/R2 sequence, waits for 0xFA, and restarts assembly at the status byte.
- R11: If no falling clock edge arrives for `TIMEOUT_CYC` cycles in the middle of a frame, the partial frame is discarded. Following frames decode normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ps2ClkIn | input | 1 | Sensed level of the PS/2 clock line |
| ps2DataIn | input | 1 | Sensed level of the PS/2 data line |
| ps2ClkLow | output | 1 | 1 pulls the PS/2 clock line low |
| ps2DataLow | output | 1 | 1 pulls the PS/2 data line low |
| pktValid | output | 1 | One-cycle strobe: packet fields are new |
| buttons | output | 3 | Middle, right, left button states |
| deltaX | output | 9 | Signed X movement |
| deltaY | output | 9 | Signed Y movement |
| ovfX | output | 1 | X movement overflow |
| ovfY | output | 1 | Y movement overflow |
| wheel | output | 8 | Signed wheel movement (fourth byte) |
| errFlag | output | 1 | One-cycle strobe on a corrupt received frame |

## Verification
The bench builds the block with `WHEEL_EN` = 1, which puts the four-byte packet and the signed wheel field in reach. It shortens `INHIBIT_CYC` to 40 cycles, so the bus-claim sequence can be measured exactly, and it runs two full command exchanges (enable and repeat request). `TIMEOUT_CYC` is 200 cycles, far above the bench's 16-cycle bit period. A stalled partial frame can therefore expire in a few hundred cycles without any legal frame coming near the limit.

// File: rtl/mph_pkg.sv
`timescale 1ns/1ps
package mph_pkg;

  localparam logic [7:0] CMD_STREAM_ON = 8'hF4;
  localparam logic [7:0] CMD_REPEAT    = 8'hFE;
  localparam logic [7:0] RSP_ACK       = 8'hFA;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic holdClk;    // pull the clock line low
    logic txLoad;     // load a command and pull data low (start bit)
    logic txRun;      // serialize the loaded command on device clock edges
    logic rxRun;      // receiver enabled
    logic repeatCmd;  // select the repeat command instead of stream-on
    logic capStatus;
    logic capX;
    logic capY;
    logic capZ;
    logic publish;    // final byte: update outputs and strobe valid
    logic flagErr;
  } ctrl_t;

endpackage

// File: rtl/mph_datapath.sv
`timescale 1ns/1ps
module mph_datapath #(
  parameter int TIMEOUT_CYC = 20000
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           ps2ClkIn,
  input  logic           ps2DataIn,
  input  mph_pkg::ctrl_t ctrl,
  output logic           rxDone,
  output logic           rxErr,
  output logic [7:0]     rxByte,
  output logic           txDone,
  output logic           ps2ClkLow,
  output logic           ps2DataLow,
  output logic           pktValid,
  output logic [2:0]     buttons,
  output logic [8:0]     deltaX,
  output logic [8:0]     deltaY,
  output logic           ovfX,
  output logic           ovfY,
  output logic [7:0]     wheel,
  output logic           errFlag
);
  import mph_pkg::*;

  localparam int IW = $clog2(TIMEOUT_CYC + 1);

  // line synchronizers and falling-edge detect
  logic clkMeta, clkSync, clkPrev, dataMeta, dataSync;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkMeta <= 1'b1; clkSync <= 1'b1; clkPrev <= 1'b1;
      dataMeta <= 1'b1; dataSync <= 1'b1;
    end else begin
      clkMeta  <= ps2ClkIn;  clkSync <= clkMeta; clkPrev <= clkSync;
      dataMeta <= ps2DataIn; dataSync <= dataMeta;
    end
  end
  logic fallEdge;
  assign fallEdge = clkPrev & ~clkSync;

  // receiver
  logic [3:0]    bitCnt;
  logic [9:0]    rxBits;
  logic [10:0]   frame;
  logic [IW-1:0] idleCnt;
  assign frame = {dataSync, rxBits};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0; rxBits <= '0; idleCnt <= '0;
      rxDone <= 1'b0; rxErr <= 1'b0; rxByte <= '0;
    end else begin
      rxDone <= 1'b0;
      if (!ctrl.rxRun) begin
        bitCnt  <= '0;
        idleCnt <= '0;
      end else if (fallEdge) begin
        idleCnt <= '0;
        if (bitCnt == 4'd10) begin
          bitCnt <= '0;
          rxDone <= 1'b1;
          rxByte <= frame[8:1];
          rxErr  <= frame[0] | ~frame[10] | ~(^frame[9:1]);
        end else begin
          bitCnt <= bitCnt + 4'd1;
          rxBits <= frame[10:1];
        end
      end else if (bitCnt != 4'd0) begin
        if (idleCnt == IW'(TIMEOUT_CYC)) begin
          bitCnt  <= '0;
          idleCnt <= '0;
        end else begin
          idleCnt <= idleCnt + 1'b1;
        end
      end
    end
  end

  // transmitter: data bits, parity, stop, then the device's ack edge
  logic [9:0] txShift;
  logic [3:0] txCnt;
  logic [7:0] cmdByte;
  assign cmdByte = ctrl.repeatCmd ? CMD_REPEAT : CMD_STREAM_ON;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '1; txCnt <= '0; txDone <= 1'b0;
      ps2ClkLow <= 1'b0; ps2DataLow <= 1'b0;
    end else begin
      txDone    <= 1'b0;
      ps2ClkLow <= ctrl.holdClk;
      if (ctrl.txLoad) begin
        ps2DataLow <= 1'b1;
        txShift    <= {1'b1, ~^cmdByte, cmdByte};
        txCnt      <= '0;
      end else if (ctrl.txRun && fallEdge) begin
        if (txCnt == 4'd10) begin
          txDone <= 1'b1;
          txCnt  <= '0;
        end else begin
          ps2DataLow <= ~txShift[0];
          txShift    <= {1'b1, txShift[9:1]};
          txCnt      <= txCnt + 4'd1;
        end
      end else if (!ctrl.txRun) begin
        ps2DataLow <= 1'b0;
      end
    end
  end

  // packet field registers: {ovfY, ovfX, signY, signX, mid, right, left}
  logic [6:0] statusReg;
  logic [7:0] xReg, yReg, zReg;
  logic [7:0] yVal, zVal;
  assign yVal = ctrl.capY ? rxByte : yReg;
  assign zVal = ctrl.capZ ? rxByte : zReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusReg <= '0; xReg <= '0; yReg <= '0; zReg <= '0;
      pktValid <= 1'b0; errFlag <= 1'b0;
      buttons <= '0; deltaX <= '0; deltaY <= '0;
      ovfX <= 1'b0; ovfY <= 1'b0; wheel <= '0;
    end else begin
      pktValid <= ctrl.publish;
      errFlag  <= ctrl.flagErr;
      if (ctrl.capStatus) statusReg <= {rxByte[7:4], rxByte[2:0]};
      if (ctrl.capX)      xReg <= rxByte;
      if (ctrl.capY)      yReg <= rxByte;
      if (ctrl.capZ)      zReg <= rxByte;
      if (ctrl.publish) begin
        buttons <= statusReg[2:0];
        deltaX  <= {statusReg[3], xReg};
        deltaY  <= {statusReg[4], yVal};
        ovfX    <= statusReg[5];
        ovfY    <= statusReg[6];
        wheel   <= zVal;
      end
    end
  end

endmodule

// File: rtl/mph_ctrl.sv
`timescale 1ns/1ps
module mph_ctrl #(
  parameter int INHIBIT_CYC = 10000,
  parameter bit WHEEL_EN    = 1'b1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           rxDone,
  input  logic           rxErr,
  input  logic [7:0]     rxByte,
  input  logic           txDone,
  output mph_pkg::ctrl_t ctrl
);
  import mph_pkg::*;

  localparam int HW = $clog2(INHIBIT_CYC + 1);

  typedef enum logic [2:0] {ST_HOLD, ST_REQ, ST_SEND, ST_ACK, ST_STREAM} state_t;
  state_t        state;
  logic [HW-1:0] holdCnt;
  logic [1:0]    idx;
  logic          repeatSel;
  logic          goodByte;

  assign goodByte = rxDone & ~rxErr;

  always_comb begin
    ctrl = '0;
    ctrl.repeatCmd = repeatSel;
    ctrl.holdClk   = (state == ST_HOLD) | (state == ST_REQ);
    ctrl.txLoad    = (state == ST_REQ);
    ctrl.txRun     = (state == ST_SEND);
    ctrl.rxRun     = (state == ST_ACK) | (state == ST_STREAM);
    if (state == ST_STREAM) begin
      ctrl.flagErr   = rxDone & rxErr;
      ctrl.capStatus = goodByte & (idx == 2'd0) & rxByte[3];
      ctrl.capX      = goodByte & (idx == 2'd1);
      ctrl.capY      = goodByte & (idx == 2'd2);
      ctrl.capZ      = goodByte & (idx == 2'd3);
      if (WHEEL_EN) ctrl.publish = ctrl.capZ;
      else          ctrl.publish = ctrl.capY;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_HOLD; holdCnt <= '0; idx <= '0; repeatSel <= 1'b0;
    end else begin
      unique case (state)
        ST_HOLD: begin
          if (holdCnt == HW'(INHIBIT_CYC - 1)) begin
            holdCnt <= '0;
            state   <= ST_REQ;
          end else begin
            holdCnt <= holdCnt + 1'b1;
          end
        end
        ST_REQ:  state <= ST_SEND;
        ST_SEND: if (txDone) state <= ST_ACK;
        ST_ACK: begin
          if (goodByte && rxByte == RSP_ACK) begin
            state <= ST_STREAM;
            idx   <= '0;
          end
        end
        ST_STREAM: begin
          if (ctrl.flagErr) begin
            state     <= ST_HOLD;
            repeatSel <= 1'b1;
            idx       <= '0;
          end else if (ctrl.capStatus) idx <= 2'd1;
          else if (ctrl.capX)          idx <= 2'd2;
          else if (ctrl.capY)          idx <= WHEEL_EN ? 2'd3 : 2'd0;
          else if (ctrl.capZ)          idx <= 2'd0;
        end
        default: state <= ST_HOLD;
      endcase
    end
  end

endmodule

// File: rtl/mouse_pkt_host.sv
`timescale 1ns/1ps
module mouse_pkt_host #(
  parameter int INHIBIT_CYC = 10000,
  parameter int TIMEOUT_CYC = 20000,
  parameter bit WHEEL_EN    = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ps2ClkIn,
  input  logic       ps2DataIn,
  output logic       ps2ClkLow,
  output logic       ps2DataLow,
  output logic       pktValid,
  output logic [2:0] buttons,
  output logic [8:0] deltaX,
  output logic [8:0] deltaY,
  output logic       ovfX,
  output logic       ovfY,
  output logic [7:0] wheel,
  output logic       errFlag
);

  mph_pkg::ctrl_t ctrlBus;
  logic           rxDone, rxErr, txDone;
  logic [7:0]     rxByte;

  mph_ctrl #(.INHIBIT_CYC(INHIBIT_CYC), .WHEEL_EN(WHEEL_EN)) uCtrl (
    .clk(clk), .rstN(rstN), .rxDone(rxDone), .rxErr(rxErr),
    .rxByte(rxByte), .txDone(txDone), .ctrl(ctrlBus)
  );

  mph_datapath #(.TIMEOUT_CYC(TIMEOUT_CYC)) uPath (
    .clk(clk), .rstN(rstN), .ps2ClkIn(ps2ClkIn), .ps2DataIn(ps2DataIn),
    .ctrl(ctrlBus), .rxDone(rxDone), .rxErr(rxErr), .rxByte(rxByte),
    .txDone(txDone), .ps2ClkLow(ps2ClkLow), .ps2DataLow(ps2DataLow),
    .pktValid(pktValid), .buttons(buttons), .deltaX(deltaX),
    .deltaY(deltaY), .ovfX(ovfX), .ovfY(ovfY), .wheel(wheel),
    .errFlag(errFlag)
  );

endmodule

// File: rtl/mph_checker.sv
`timescale 1ns/1ps
module mph_checker #(
  parameter int INHIBIT_CYC = 10000
) (
  input logic clk,
  input logic rstN,
  input logic ps2ClkLow,
  input logic ps2DataLow,
  input logic pktValid,
  input logic errFlag
);
  localparam int CW = $clog2(INHIBIT_CYC + 2);

  // length of the current clock-hold interval, saturating
  logic [CW-1:0] heldCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            heldCnt <= '0;
    else if (!ps2ClkLow)                  heldCnt <= '0;
    else if (heldCnt != {CW{1'b1}})       heldCnt <= heldCnt + 1'b1;
  end

  assert_hold_len_R1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ps2ClkLow) |-> (heldCnt >= CW'(INHIBIT_CYC)));

  assert_req_order_R1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ps2ClkLow) |-> ps2DataLow);

  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |=> !pktValid);

  assert_err_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> !errFlag);

  assert_err_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(errFlag && pktValid));

endmodule

bind mouse_pkt_host mph_checker #(.INHIBIT_CYC(INHIBIT_CYC)) uChk (
  .clk(clk), .rstN(rstN), .ps2ClkLow(ps2ClkLow), .ps2DataLow(ps2DataLow),
  .pktValid(pktValid), .errFlag(errFlag)
);

// File: tb/sim_mouse_pkt_host.sv
`timescale 1ns/1ps
module sim_mouse_pkt_host;
  localparam int INH  = 40;
  localparam int TMO  = 200;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic mClk = 1'b1, mData = 1'b1;
  logic ps2ClkLow, ps2DataLow, pktValid, ovfX, ovfY, errFlag;
  logic [2:0] buttons;
  logic [8:0] deltaX, deltaY;
  logic [7:0] wheel;
  logic ps2ClkIn, ps2DataIn;
  assign ps2ClkIn  = mClk & ~ps2ClkLow;
  assign ps2DataIn = mData & ~ps2DataLow;

  mouse_pkt_host #(.INHIBIT_CYC(INH), .TIMEOUT_CYC(TMO), .WHEEL_EN(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .ps2ClkIn(ps2ClkIn), .ps2DataIn(ps2DataIn),
    .ps2ClkLow(ps2ClkLow), .ps2DataLow(ps2DataLow), .pktValid(pktValid),
    .buttons(buttons), .deltaX(deltaX), .deltaY(deltaY), .ovfX(ovfX),
    .ovfY(ovfY), .wheel(wheel), .errFlag(errFlag)
  );

  int checks = 0, errors = 0, errPulses = 0, pktCount = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [2:0] btn;
    logic [8:0] dx, dy;
    logic       ox, oy;
    logic [7:0] z;
  } exp_t;
  exp_t expQ[$];

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic halfWait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    mData = b; halfWait(); mClk = 1'b0; halfWait(); mClk = 1'b1;
  endtask

  task automatic sendByte(input logic [7:0] b, input bit badPar);
    sendBit(1'b0);
    for (int i = 0; i < 8; i++) sendBit(b[i]);
    sendBit((~^b) ^ badPar);
    sendBit(1'b1);
    mData = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  // device-side reception of a host command
  task automatic recvCmd(output logic [7:0] b, output int held, output bit reqOk,
                         output bit parOk, output bit stopOk);
    logic [10:1] bits;
    held = 0;
    while (!ps2ClkLow) @(negedge clk);
    while (ps2ClkLow) begin held++; @(negedge clk); end
    reqOk = ps2DataLow;
    for (int k = 1; k <= 11; k++) begin
      if (k == 11) mData = 1'b0;
      halfWait(); mClk = 1'b0; halfWait();
      if (k <= 10) bits[k] = ps2DataIn;
      mClk = 1'b1;
    end
    halfWait(); mData = 1'b1;
    b      = bits[8:1];
    parOk  = (^bits[9:1]) == 1'b1;
    stopOk = bits[10];
    repeat (20) @(negedge clk);
  endtask

  task automatic sendPacket(input logic [7:0] st, input logic [7:0] x,
                            input logic [7:0] y, input logic [7:0] z);
    exp_t e;
    e.btn = st[2:0]; e.dx = {st[4], x}; e.dy = {st[5], y};
    e.ox = st[6]; e.oy = st[7]; e.z = z;
    expQ.push_back(e);
    sendByte(st, 1'b0); sendByte(x, 1'b0); sendByte(y, 1'b0); sendByte(z, 1'b0);
    repeat (40) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (errFlag) errPulses++;
      if (pktValid) begin
        pktCount++;
        if (expQ.size() == 0) begin
          check("R3", "unexpected packet", 1, 0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check("R6", "deltaX", deltaX, e.dx);
          check("R6", "deltaY", deltaY, e.dy);
          check("R7", "buttons", buttons, e.btn);
          check("R7", "overflow", {ovfY, ovfX}, {e.oy, e.ox});
          check("R8", "wheel", wheel, e.z);
        end
      end
    end
  end

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      done = 1'b1;
      finishRun();
    end
  end

  initial begin
    logic [7:0] cmd;
    int held;
    bit reqOk, parOk, stopOk;

    repeat (4) @(negedge clk);
    check("R1", "reset pull-lows", {ps2ClkLow, ps2DataLow}, 0);
    check("R1", "reset strobes", {pktValid, errFlag}, 0);
    rstN = 1'b1;

    // bus claim and enable command
    recvCmd(cmd, held, reqOk, parOk, stopOk);
    check("R1", "clock hold >= INH", held >= INH, 1);
    check("R1", "data low at clock release", reqOk, 1);
    check("R2", "command byte", cmd, 8'hF4);
    check("R2", "odd parity", parOk, 1);
    check("R2", "stop bit", stopOk, 1);

    // traffic before the acknowledge is ignored
    sendByte(8'h08, 1'b0); sendByte(8'h11, 1'b0);
    sendByte(8'h22, 1'b0); sendByte(8'h33, 1'b0);
    sendByte(8'h44, 1'b1);
    repeat (40) @(negedge clk);
    check("R3", "packets before ack", pktCount, 0);
    check("R3", "errors before ack", errPulses, 0);
    sendByte(8'hFA, 1'b0);

    // movement patterns
    sendPacket(8'h09, 8'h05, 8'h03, 8'h00);
    sendPacket(8'h3A, 8'hF0, 8'h80, 8'hFF);
    sendPacket(8'hCC, 8'hFF, 8'h00, 8'h01);
    check("R5", "packets after three", pktCount, 3);

    // R9 resync: status candidate with bit 3 clear is dropped
    sendByte(8'h00, 1'b0);
    sendPacket(8'h0B, 8'h01, 8'h02, 8'h03);
    check("R9", "packets after resync", pktCount, 4);

    // R11: stalled partial frame
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b0);
    mData = 1'b1;
    repeat (TMO + 60) @(negedge clk);
    sendPacket(8'h18, 8'h80, 8'h7F, 8'h80);
    check("R11", "packets after timeout", pktCount, 5);
    check("R4", "no error from timeout", errPulses, 0);

    // R10: corrupt Y byte triggers error and repeat request
    sendByte(8'h09, 1'b0); sendByte(8'h10, 1'b0); sendByte(8'h20, 1'b1);
    recvCmd(cmd, held, reqOk, parOk, stopOk);
    check("R4", "error pulses", errPulses, 1);
    check("R10", "repeat command byte", cmd, 8'hFE);
    check("R10", "repeat parity", parOk, 1);
    check("R10", "repeat request order", reqOk, 1);
    check("R10", "no packet from partial", pktCount, 5);
    sendByte(8'hFA, 1'b0);
    sendPacket(8'h09, 8'h10, 8'h20, 8'h30);

    check("R5", "total packets", pktCount, 6);
    check("R5", "scoreboard drained", expQ.size(), 0);
    done = 1'b1;
    finishRun();
  end

endmodule